// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked host and a 32-bit asynchronous static memory built from four independent 8-bit lanes. All lanes share one address bus and one active-low output enable. Each lane has its own active-low enable and its own active-low write strobe, so a single access can touch any subset of the four bytes. The host hands over one request at a time on a valid/ready channel: a 19-bit word address, a write flag, a 4-bit lane mask and 32 bits of write data. Reads return a 32-bit word with a one-cycle valid strobe.

Every phase length is computed at elaboration from the clock period and the memory's nanosecond limits, each rounded up to whole cycles. A read drives the address, the selected lane enables and the output enable in the acceptance cycle, then samples the bus once the access time has elapsed. A write keeps the output enable high for the whole cycle, so the memory never drives the bus when the controller does. The data bus is driven from the cycle the strobe falls until the hold time after it rises. A recovery phase keeps the strobes high between accesses.

Top module: `sram_lane_ctrl`

## Requirements
- R1: `req_ready` is high when idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is then low for RD+REC cycles after a read and for 1+WP+HOLD+REC cycles after a write. Requests presented while it is low have no effect.
- R2: During an access, `mem_ce_n[i]` is low exactly when bit i of the accepted mask is 1. With an all-zero mask, no lane enable goes low.
- R3: A write strobe goes low only on lanes whose enable is low and whose mask bit is set. It falls one cycle after acceptance and stays low for WP = max(ceil(20 ns/T), ceil(15 ns/T), 1) cycles.
- R4: `mem_oe_n` stays high throughout a write. `mem_dq_oe` rises with the strobe and stays high for HOLD = max(ceil(2 ns/T), 1) cycles after the strobe rises. It is never high while `mem_oe_n` is low.
- R5: `mem_addr` holds the accepted address, unchanged, for as long as any lane enable is low.
- R6: A read drives `mem_oe_n` and the selected enables low from the acceptance edge. The bus is sampled RD = max(ceil(25 ns/T), 3) cycles after acceptance, so `rsp_valid` appears RD cycles after the accepting edge.
- R7: `rsp_valid` is a single-cycle pulse. In `rsp_rdata`, bits 8i+7:8i hold lane i. Lanes outside the mask read as zero.
- R8: After reset: `req_ready`=1, all enables and strobes high, `mem_oe_n`=1, `mem_dq_oe`=0, `rsp_valid`=0, `rsp_rdata`=0.
- R9: After an access ends, all enables and strobes remain high for REC cycles before the next access can begin. REC is at least max(ceil(5 ns/T), 1) and is long enough to give a 25 ns minimum cycle.
- R10: Byte i of `req_wdata` drives `mem_dq_out` bits 8i+7:8i. Memory lanes outside the mask keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 19 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 4 | Lane select, bit i = byte i |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 32 | Read data, unselected lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 4 | Per-lane enable, active low |
| mem_we_n | output | 4 | Per-lane write strobe, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 32 | Data toward memory |
| mem_dq_in | input | 32 | Data from memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The checker assumes reset is applied before any request. It places no demand on `req_valid` or the request fields: it observes only what the controller drives, plus the handshake. The stimulus keeps each request's fields stable from the time `req_valid` rises until acceptance. Only in the busy-window test does it change them on purpose, and then only while `req_ready` is low, which exercises R1's "no effect" case. The memory model answers on `mem_dq_in` only while an enabled, non-writing lane sees `mem_oe_n` low, and drives a marker byte otherwise. A capture taken outside the read window therefore shows up as a data mismatch.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RECOVER
  } ctrl_state_e;

  // whole cycles covering a time limit, rounded up
  function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_lane_slice.sv
module sram_lane_slice #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_in,
  input  logic              acc_start,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic              acc_end,
  input  logic              capture,
  input  logic [LANE_W-1:0] wbyte,
  input  logic [LANE_W-1:0] dq_in,
  output logic              ce_n,
  output logic              we_n,
  output logic [LANE_W-1:0] dq_out,
  output logic [LANE_W-1:0] rbyte
);

  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      ce_n   <= 1'b1;
      we_n   <= 1'b1;
      dq_out <= '0;
      rbyte  <= '0;
    end else begin
      if (acc_start) begin
        sel_q  <= sel_in;
        ce_n   <= ~sel_in;
        dq_out <= wbyte;
      end
      if (acc_end) ce_n <= 1'b1;
      if (wr_start) we_n <= ~sel_q;
      if (wr_end) we_n <= 1'b1;
      if (capture) rbyte <= sel_q ? dq_in : '0;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int ADDR_W      = 19,
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  parameter int T_RD_PS     = 25000,
  parameter int T_WRLOW_PS  = 20000,
  parameter int T_DSETUP_PS = 15000,
  parameter int T_DHOLD_PS  = 2000,
  parameter int T_WRHIGH_PS = 5000,
  parameter int T_CYCLE_PS  = 25000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [LANES-1:0]         req_mask,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  output logic                     rsp_valid,
  output logic [LANES*LANE_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [LANES-1:0]         mem_ce_n,
  output logic [LANES-1:0]         mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES*LANE_W-1:0]  mem_dq_out,
  input  logic [LANES*LANE_W-1:0]  mem_dq_in,
  output logic                     mem_dq_oe
);

  localparam int RD_CYC   = max2(ps_to_cyc(T_RD_PS, CLK_PS), 3);
  localparam int WP_CYC   = max2(max2(ps_to_cyc(T_WRLOW_PS, CLK_PS),
                                      ps_to_cyc(T_DSETUP_PS, CLK_PS)), 1);
  localparam int HOLD_CYC = max2(ps_to_cyc(T_DHOLD_PS, CLK_PS), 1);
  localparam int CYC_MIN  = ps_to_cyc(T_CYCLE_PS, CLK_PS);
  localparam int REC_CYC  = max2(max2(ps_to_cyc(T_WRHIGH_PS, CLK_PS), 1),
                                 max2(CYC_MIN - RD_CYC,
                                      CYC_MIN - (1 + WP_CYC + HOLD_CYC)));
  localparam int MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(HOLD_CYC, REC_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] RW_LOAD   = CNT_W'(RD_CYC - 3);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD  = CNT_W'(REC_CYC - 1);

  ctrl_state_e state;
  logic        fire, wr_start, wr_end, capture, acc_end;
  logic        t_load, t_expired;
  logic [CNT_W-1:0] t_val;

  assign fire     = req_valid & req_ready;
  assign wr_start = (state == ST_WR_SETUP);
  assign wr_end   = (state == ST_WR_PULSE) & t_expired;
  assign capture  = (state == ST_RD_CAPT);
  assign acc_end  = capture | ((state == ST_WR_HOLD) & t_expired);

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (state == ST_RD_SETUP) begin
      t_load = 1'b1;
      t_val  = RW_LOAD;
    end else if (wr_start) begin
      t_load = 1'b1;
      t_val  = WP_LOAD;
    end else if (wr_end) begin
      t_load = 1'b1;
      t_val  = HOLD_LOAD;
    end else if (acc_end) begin
      t_load = 1'b1;
      t_val  = REC_LOAD;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      mem_addr  <= '0;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      rsp_valid <= capture;
      unique case (state)
        ST_IDLE: begin
          if (fire) begin
            req_ready <= 1'b0;
            mem_addr  <= req_addr;
            mem_oe_n  <= req_write;
            state     <= req_write ? ST_WR_SETUP : ST_RD_SETUP;
          end
        end
        ST_RD_SETUP: state <= ST_RD_WAIT;
        ST_RD_WAIT:  if (t_expired) state <= ST_RD_CAPT;
        ST_RD_CAPT: begin
          mem_oe_n <= 1'b1;
          state    <= ST_RECOVER;
        end
        ST_WR_SETUP: begin
          mem_dq_oe <= 1'b1;
          state     <= ST_WR_PULSE;
        end
        ST_WR_PULSE: if (t_expired) state <= ST_WR_HOLD;
        ST_WR_HOLD: begin
          if (t_expired) begin
            mem_dq_oe <= 1'b0;
            state     <= ST_RECOVER;
          end
        end
        ST_RECOVER: begin
          if (t_expired) begin
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_slice #(.LANE_W(LANE_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .sel_in    (req_mask[g]),
      .acc_start (fire),
      .wr_start  (wr_start),
      .wr_end    (wr_end),
      .acc_end   (acc_end),
      .capture   (capture),
      .wbyte     (req_wdata[g*LANE_W +: LANE_W]),
      .dq_in     (mem_dq_in[g*LANE_W +: LANE_W]),
      .ce_n      (mem_ce_n[g]),
      .we_n      (mem_we_n[g]),
      .dq_out    (mem_dq_out[g*LANE_W +: LANE_W]),
      .rbyte     (rsp_rdata[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
  import sram_lane_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int ADDR_W      = 19,
  parameter int LANES       = 4,
  parameter int T_WRLOW_PS  = 20000,
  parameter int T_DSETUP_PS = 15000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_ce_n,
  input logic [LANES-1:0]  mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  localparam int PULSE = max2(max2(ps_to_cyc(T_WRLOW_PS, CLK_PS),
                                   ps_to_cyc(T_DSETUP_PS, CLK_PS)), 1);

  logic any_ce, any_we;
  int   we_run;

  assign any_ce = ~&mem_ce_n;
  assign any_we = ~&mem_we_n;

  always_ff @(posedge clk) begin
    if (rst) we_run <= 0;
    else if (any_we) we_run <= we_run + 1;
    else we_run <= 0;
  end

  assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_strobe_inside_enable_R3: assert property (@(posedge clk) disable iff (rst)
    ((~mem_we_n & mem_ce_n) == '0));

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(any_we) && !any_we) |-> (we_run == PULSE));

  assert_drive_needs_oe_off_R4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_strobe_with_drive_R4: assert property (@(posedge clk) disable iff (rst)
    any_we |-> mem_dq_oe);

  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (any_ce && $past(any_ce)) |-> $stable(mem_addr));

  assert_read_after_oe_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!mem_oe_n));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .CLK_PS      (CLK_PS),
  .ADDR_W      (ADDR_W),
  .LANES       (LANES),
  .T_WRLOW_PS  (T_WRLOW_PS),
  .T_DSETUP_PS (T_DSETUP_PS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  // 8 ns clock: RD=ceil(25/8)=4, WP=ceil(20/8)=3, HOLD=1, REC=1
  localparam int E_RD   = 4;
  localparam int E_WP   = 3;
  localparam int E_HOLD = 1;
  localparam int E_REC  = 1;

  typedef struct packed {
    logic        wr;
    logic [3:0]  mask;
    logic [18:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'hF, 19'h00010, 32'h11223344, 32'h0},
    '{1'b1, 4'h1, 19'h7FFFF, 32'hAABBCCDD, 32'h0},
    '{1'b0, 4'hF, 19'h00010, 32'h0,        32'h11223344},
    '{1'b1, 4'h6, 19'h00010, 32'h55667788, 32'h0},
    '{1'b0, 4'hF, 19'h00010, 32'h0,        32'h11667744},
    '{1'b0, 4'h5, 19'h00010, 32'h0,        32'h00660044},
    '{1'b0, 4'hF, 19'h7FFFF, 32'h0,        32'h000000DD},
    '{1'b1, 4'h8, 19'h7FFFF, 32'h99000000, 32'h0},
    '{1'b0, 4'hF, 19'h7FFFF, 32'h0,        32'h990000DD},
    '{1'b0, 4'h0, 19'h00010, 32'h0,        32'h00000000},
    '{1'b0, 4'hA, 19'h00010, 32'h0,        32'h11007700}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [18:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_mask = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic [3:0]  mem_ce_n, mem_we_n;
  logic        mem_oe_n;
  logic [31:0] mem_dq_out;
  logic [31:0] mem_dq_in;
  logic        mem_dq_oe;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.CLK_PS(8000)) i_sram_lane_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_mask(req_mask),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  // memory model: byte lanes written on strobe rise, read while enabled with oe low
  logic [31:0] model_mem [logic [18:0]];
  logic [3:0]  we_prev = 4'hF;

  always @(mem_we_n) begin
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      if (!we_prev[i] && mem_we_n[i] && !mem_ce_n[i]) begin
        w = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 32'h0;
        w[8*i +: 8] = mem_dq_out[8*i +: 8];
        model_mem[mem_addr] = w;
      end
    end
    we_prev = mem_we_n;
  end

  always @(mem_ce_n or mem_we_n or mem_oe_n or mem_addr) begin
    logic [31:0] w;
    w = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 32'h0;
    for (int i = 0; i < 4; i++)
      mem_dq_in[8*i +: 8] = (!mem_ce_n[i] && mem_we_n[i] && !mem_oe_n) ? w[8*i +: 8] : 8'hEE;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_access(input vec_t v, input int junk);
    int n = 0, busy = 0, we_cnt = 0, dq_cnt = 0, oe_low = 0, rv_cnt = 0, rv_at = 0;
    int ce_cnt = 0, ce_bad = 0, we_bad = 0, addr_bad = 0;
    logic [31:0] rdat = '0;
    @(negedge clk);
    req_addr = v.addr; req_write = v.wr; req_mask = v.mask; req_wdata = v.wdata;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    forever begin
      @(negedge clk);
      n++;
      if (n <= junk) begin
        req_addr = 19'h00010; req_write = 1'b1; req_mask = 4'hF; req_wdata = 32'hFFFFFFFF;
      end else begin
        req_valid = 1'b0;
      end
      if (req_ready) break;
      busy++;
      if (mem_ce_n != 4'hF) begin
        ce_cnt++;
        if (mem_ce_n != ~v.mask) ce_bad++;
        if (mem_addr != v.addr) addr_bad++;
      end
      if (mem_we_n != 4'hF) begin
        we_cnt++;
        if (mem_we_n != ~v.mask) we_bad++;
      end
      if (mem_dq_oe) dq_cnt++;
      if (v.wr && !mem_oe_n) oe_low++;
      if (rsp_valid) begin
        rv_cnt++; rv_at = n; rdat = rsp_rdata;
      end
    end
    req_valid = 1'b0;
    if (v.wr) begin
      chk(busy == 1 + E_WP + E_HOLD + E_REC, "R1 write busy cycles", busy, 1 + E_WP + E_HOLD + E_REC);
      chk(we_cnt == ((v.mask != 0) ? E_WP : 0), "R3 strobe width", we_cnt, E_WP);
      chk(dq_cnt == E_WP + E_HOLD, "R4 drive window", dq_cnt, E_WP + E_HOLD);
      chk(oe_low == 0, "R4 oe low in write", oe_low, 0);
      chk(ce_cnt == ((v.mask != 0) ? 1 + E_WP + E_HOLD : 0), "R2 write enable cycles", ce_cnt, 1 + E_WP + E_HOLD);
    end else begin
      chk(busy == E_RD + E_REC, "R1 read busy cycles", busy, E_RD + E_REC);
      chk(rv_cnt == 1, "R7 valid pulse count", rv_cnt, 1);
      chk(rv_at == E_RD + 1, "R6 read latency", rv_at, E_RD + 1);
      chk(rdat == v.exp, "R7 R10 read data", rdat, v.exp);
      chk(ce_cnt == ((v.mask != 0) ? E_RD : 0), "R2 read enable cycles", ce_cnt, E_RD);
    end
    chk(ce_bad == 0, "R2 lane enables", ce_bad, 0);
    chk(we_bad == 0, "R3 lane strobes", we_bad, 0);
    chk(addr_bad == 0, "R5 address hold", addr_bad, 0);
    // R9: idle gap after the access
    chk(mem_ce_n == 4'hF && mem_we_n == 4'hF && !mem_dq_oe, "R9 idle after access",
        {mem_ce_n, mem_we_n}, 8'hFF);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(req_ready == 1'b1, "R8 ready", req_ready, 1);
    chk(mem_ce_n == 4'hF, "R8 enables", mem_ce_n, 4'hF);
    chk(mem_we_n == 4'hF, "R8 strobes", mem_we_n, 4'hF);
    chk(mem_oe_n == 1'b1, "R8 oe", mem_oe_n, 1);
    chk(mem_dq_oe == 1'b0, "R8 drive", mem_dq_oe, 0);
    chk(rsp_valid == 1'b0 && rsp_rdata == 0, "R8 response", rsp_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);

    for (int k = 0; k < NV; k++) run_access(VECS[k], 0);

    // R1: a junk write held during the busy window must not be taken
    run_access('{1'b0, 4'h3, 19'h00010, 32'h0, 32'h00007744}, 3);
    run_access('{1'b0, 4'hF, 19'h00010, 32'h0, 32'h11667744}, 0);

    // R10: lane 3 only write leaves other lanes, full read back
    run_access('{1'b1, 4'h8, 19'h00010, 32'hC3000000, 32'h0}, 0);
    run_access('{1'b0, 4'hF, 19'h00010, 32'h0, 32'hC3667744}, 0);

    // R8: reset in the middle of a read returns to idle
    @(negedge clk);
    req_addr = 19'h00010; req_write = 1'b0; req_mask = 4'hF; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n == 4'hF && mem_oe_n, "R8 mid-access reset",
        {req_ready, mem_ce_n, mem_oe_n}, 6'h3F);
    rst = 1'b0;
    run_access('{1'b0, 4'hC, 19'h00010, 32'h0, 32'hC3660000}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule